// File: doc/BRIEF.md
# Single-Wire Bus Host Engine

This block is the host side of a single-wire, open-drain serial bus. The slave on this bus draws its power from the same line. A local command port accepts one command at a time: bus reset with device discovery, start, stop, byte write or byte read. The engine turns each command into a run of fixed-length bit frames on the line.

The host opens every frame by pulling the line low. The length of that low pulse is what encodes a one, a zero, a start or a stop. In frames where the slave answers, the host releases the line after a short pulse and samples it at a fixed offset. The engine never drives the line high. Its only line output is a pull-low enable, and it reads the line back through a separate input.

All durations are clock-count parameters. There are two sets of them, standard speed and high speed, and the set is chosen when a command is accepted. When a command ends, the engine pulses `done`. At that point the received byte, the acknowledge bit and the discovery result are valid.

Top module: `swb_host`

## Requirements
- R1: After reset, pull_low, busy and done are 0, and rx_data, rx_nack and present are all 0.
- R2: cmd_op values are 1 = bus reset/discovery, 2 = start, 3 = stop, 4 = write byte, 5 = read byte. When busy is 0, a cmd_valid with a legal op is accepted at the clock edge and busy reads 1 in the next cycle. Ops 0, 6 and 7 are ignored and busy stays 0.
- R3: Every data, start, stop and discovery frame lasts BIT clock cycles. pull_low is 1 for the first L cycles of a frame and 0 for the rest. The standard set is BIT=24, one=3, zero=12, stop=17, start=21, sample offset=8, reset=120, recovery=10, discovery low=2, discovery sample=6. The high-speed set is BIT=12, one=2, zero=7, stop=9, start=10, sample offset=4, reset=48, recovery=6, discovery low=1, discovery sample=3.
- R4: A write sends cmd_data most-significant bit first, using low time "one" for a 1 and "zero" for a 0. A ninth frame follows with low time "one", and the line is sampled at the sample offset. rx_nack takes the sampled level (low = ACK = 0, high = NACK = 1).
- R5: A read runs eight frames with low time "one", each sampled at the sample offset. A low line gives bit 0 and a high line gives bit 1, assembled most-significant bit first into rx_data. A ninth frame then sends cmd_ack_bit (1 = NACK with low time "one", 0 = ACK with low time "zero"), and rx_nack reports that bit.
- R6: Start and stop are each one frame, with low time "start" or "stop" respectively.
- R7: A bus reset holds the line low for the reset time. It then releases the line for the recovery time, then runs a discovery frame with low time "discovery low" and samples at "discovery sample". present becomes 1 if the line was low at that sample and 0 if it was high.
- R8: The frames of a command follow one another with no idle cycle. busy stays 1 for exactly the sum of the frame lengths.
- R9: done is a one-cycle pulse in the cycle after the last frame cycle, and busy is 0 in that same cycle. rx_data, rx_nack and present change only at done.
- R10: cmd_valid while busy is 1 is ignored and does not alter the running frame sequence.
- R11: pull_low is never 1 while busy is 0.
- R12: The speed set is taken from speed_hi at acceptance. Changing speed_hi during a command has no effect on that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_data | input | 8 | Byte to write |
| cmd_ack_bit | input | 1 | Bit the host returns after a read byte (1 = NACK) |
| speed_hi | input | 1 | 1 selects the high-speed timing set |
| line_in | input | 1 | Level read back from the bus line |
| pull_low | output | 1 | 1 pulls the bus line low, 0 releases it |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last byte read |
| rx_nack | output | 1 | Last acknowledge bit (0 = ACK) |
| present | output | 1 | Last discovery result |

## Verification
busy rises one cycle after the accepting edge. From that cycle on, the frame counter puts pull_low for frame cycle j in the j-th cycle after acceptance, with no gap between frames. done and the result outputs appear in the single cycle after the final frame cycle. The bench expands each command into a per-cycle queue of expected pull_low levels and slave pull-down levels. At every falling edge it pops one entry, compares pull_low and busy against it and drives the slave model from it. It then checks done and the results exactly one cycle after the queue empties, and checks that done is low again one cycle later.

// File: rtl/swb_pkg.sv
package swb_pkg;

  localparam int SWB_TW = 16;
  typedef logic [SWB_TW-1:0] swb_cnt_t;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_RESET = 3'd1,
    OP_START = 3'd2,
    OP_STOP  = 3'd3,
    OP_WRITE = 3'd4,
    OP_READ  = 3'd5
  } swb_op_e;

  // one frame: total length, low time, sample offset, sample enable
  typedef struct packed {
    swb_cnt_t len;
    swb_cnt_t low;
    swb_cnt_t smp;
    logic     smp_en;
  } swb_frame_t;

  // one complete timing set
  typedef struct packed {
    swb_cnt_t bit_len;
    swb_cnt_t low1;
    swb_cnt_t low0;
    swb_cnt_t low_sta;
    swb_cnt_t low_stp;
    swb_cnt_t smp;
    swb_cnt_t rst;
    swb_cnt_t rec;
    swb_cnt_t dlow;
    swb_cnt_t dsmp;
  } swb_tset_t;

  function automatic logic swb_op_legal(logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd5);
  endfunction

  function automatic logic [3:0] swb_steps(swb_op_e op);
    case (op)
      OP_RESET: return 4'd3;
      OP_WRITE,
      OP_READ:  return 4'd9;
      default:  return 4'd1;
    endcase
  endfunction

  function automatic swb_frame_t swb_mk(swb_cnt_t len, swb_cnt_t low,
                                        swb_cnt_t smp, logic en);
    swb_frame_t f;
    f.len    = len;
    f.low    = low;
    f.smp    = smp;
    f.smp_en = en;
    return f;
  endfunction

  // frame for a given step of a command
  function automatic swb_frame_t swb_plan(swb_op_e op, swb_tset_t ts,
                                          logic [3:0] step, logic dbit,
                                          logic ackb);
    swb_frame_t f;
    case (op)
      OP_RESET: begin
        if (step == 4'd0)      f = swb_mk(ts.rst, ts.rst, '0, 1'b0);
        else if (step == 4'd1) f = swb_mk(ts.rec, '0, '0, 1'b0);
        else                   f = swb_mk(ts.bit_len, ts.dlow, ts.dsmp, 1'b1);
      end
      OP_START: f = swb_mk(ts.bit_len, ts.low_sta, '0, 1'b0);
      OP_STOP:  f = swb_mk(ts.bit_len, ts.low_stp, '0, 1'b0);
      OP_WRITE: begin
        if (step < 4'd8) f = swb_mk(ts.bit_len, dbit ? ts.low1 : ts.low0, '0, 1'b0);
        else             f = swb_mk(ts.bit_len, ts.low1, ts.smp, 1'b1);
      end
      OP_READ: begin
        if (step < 4'd8) f = swb_mk(ts.bit_len, ts.low1, ts.smp, 1'b1);
        else             f = swb_mk(ts.bit_len, ackb ? ts.low1 : ts.low0, '0, 1'b0);
      end
      default: f = swb_mk(ts.bit_len, '0, '0, 1'b0);
    endcase
    return f;
  endfunction

endpackage

// File: rtl/swb_tsel.sv
module swb_tsel
  import swb_pkg::*;
#(
  parameter int STD_BIT  = 24,
  parameter int STD_ONE  = 3,
  parameter int STD_ZERO = 12,
  parameter int STD_STP  = 17,
  parameter int STD_STA  = 21,
  parameter int STD_SMP  = 8,
  parameter int STD_RST  = 120,
  parameter int STD_REC  = 10,
  parameter int STD_DLOW = 2,
  parameter int STD_DSMP = 6,
  parameter int HS_BIT   = 12,
  parameter int HS_ONE   = 2,
  parameter int HS_ZERO  = 7,
  parameter int HS_STP   = 9,
  parameter int HS_STA   = 10,
  parameter int HS_SMP   = 4,
  parameter int HS_RST   = 48,
  parameter int HS_REC   = 6,
  parameter int HS_DLOW  = 1,
  parameter int HS_DSMP  = 3
) (
  input  logic      hs,
  output swb_tset_t ts
);

  function automatic swb_tset_t mk_set(int b, int l1, int l0, int stp, int sta,
                                       int smp, int rst, int rec, int dl, int ds);
    swb_tset_t t;
    t.bit_len = swb_cnt_t'(b);
    t.low1    = swb_cnt_t'(l1);
    t.low0    = swb_cnt_t'(l0);
    t.low_stp = swb_cnt_t'(stp);
    t.low_sta = swb_cnt_t'(sta);
    t.smp     = swb_cnt_t'(smp);
    t.rst     = swb_cnt_t'(rst);
    t.rec     = swb_cnt_t'(rec);
    t.dlow    = swb_cnt_t'(dl);
    t.dsmp    = swb_cnt_t'(ds);
    return t;
  endfunction

  localparam swb_tset_t SET_STD = mk_set(STD_BIT, STD_ONE, STD_ZERO, STD_STP, STD_STA,
                                         STD_SMP, STD_RST, STD_REC, STD_DLOW, STD_DSMP);
  localparam swb_tset_t SET_HS  = mk_set(HS_BIT, HS_ONE, HS_ZERO, HS_STP, HS_STA,
                                         HS_SMP, HS_RST, HS_REC, HS_DLOW, HS_DSMP);

  assign ts = hs ? SET_HS : SET_STD;

endmodule

// File: rtl/swb_frame.sv
module swb_frame
  import swb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  swb_frame_t frm,
  input  logic       line_in,
  output logic       pull_low,
  output logic       frame_end,
  output logic       sample_stb,
  output logic       smp_bit,
  output logic       active
);

  swb_frame_t cur;
  swb_cnt_t   cnt;

  assign frame_end  = active && (cnt == cur.len - swb_cnt_t'(1));
  assign sample_stb = active && cur.smp_en && (cnt == cur.smp);
  assign pull_low   = active && (cnt < cur.low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      cur     <= '0;
      smp_bit <= 1'b0;
    end else begin
      if (sample_stb) smp_bit <= line_in;
      if (load) begin
        active <= 1'b1;
        cnt    <= '0;
        cur    <= frm;
      end else if (frame_end) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cnt + swb_cnt_t'(1);
      end
    end
  end

endmodule

// File: rtl/swb_seq.sv
module swb_seq
  import swb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_ack_bit,
  input  swb_tset_t  ts_in,
  input  logic       frame_end,
  input  logic       smp_bit,
  output logic       load,
  output swb_frame_t frm,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       rx_nack,
  output logic       present
);

  swb_op_e    op_q;
  swb_tset_t  ts_q;
  logic [3:0] step_q;
  logic [6:0] dsr;
  logic [7:0] rsr;
  logic       ack_q;
  logic       accept;
  logic       last;

  assign accept = cmd_valid && !busy && swb_op_legal(cmd_op);
  assign last   = frame_end && (step_q == 4'(swb_steps(op_q) - 4'd1));
  assign load   = accept || (frame_end && !last);

  always_comb begin
    if (accept)
      frm = swb_plan(swb_op_e'(cmd_op), ts_in, 4'd0, cmd_data[7], cmd_ack_bit);
    else
      frm = swb_plan(op_q, ts_q, 4'(step_q + 4'd1), dsr[6], ack_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      op_q    <= OP_NONE;
      ts_q    <= '0;
      step_q  <= '0;
      dsr     <= '0;
      rsr     <= '0;
      ack_q   <= 1'b0;
      rx_data <= '0;
      rx_nack <= 1'b0;
      present <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        op_q   <= swb_op_e'(cmd_op);
        ts_q   <= ts_in;
        step_q <= '0;
        dsr    <= cmd_data[6:0];
        rsr    <= '0;
        ack_q  <= cmd_ack_bit;
      end else if (frame_end) begin
        dsr <= {dsr[5:0], 1'b0};
        if (op_q == OP_READ && step_q < 4'd8) rsr <= {rsr[6:0], smp_bit};
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          case (op_q)
            OP_RESET: present <= ~smp_bit;
            OP_WRITE: rx_nack <= smp_bit;
            OP_READ: begin
              rx_data <= rsr;
              rx_nack <= ack_q;
            end
            default: ;
          endcase
        end else begin
          step_q <= 4'(step_q + 4'd1);
        end
      end
    end
  end

endmodule

// File: rtl/swb_host.sv
module swb_host
  import swb_pkg::*;
#(
  parameter int STD_BIT  = 24,
  parameter int STD_ONE  = 3,
  parameter int STD_ZERO = 12,
  parameter int STD_STP  = 17,
  parameter int STD_STA  = 21,
  parameter int STD_SMP  = 8,
  parameter int STD_RST  = 120,
  parameter int STD_REC  = 10,
  parameter int STD_DLOW = 2,
  parameter int STD_DSMP = 6,
  parameter int HS_BIT   = 12,
  parameter int HS_ONE   = 2,
  parameter int HS_ZERO  = 7,
  parameter int HS_STP   = 9,
  parameter int HS_STA   = 10,
  parameter int HS_SMP   = 4,
  parameter int HS_RST   = 48,
  parameter int HS_REC   = 6,
  parameter int HS_DLOW  = 1,
  parameter int HS_DSMP  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_ack_bit,
  input  logic       speed_hi,
  input  logic       line_in,
  output logic       pull_low,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       rx_nack,
  output logic       present
);

  swb_tset_t  ts_w;
  swb_frame_t frm_w;
  logic       load_w;
  logic       frame_end_w;
  logic       sample_stb_w;
  logic       smp_bit_w;
  logic       frame_act_w;

  swb_tsel #(
    .STD_BIT(STD_BIT), .STD_ONE(STD_ONE), .STD_ZERO(STD_ZERO), .STD_STP(STD_STP),
    .STD_STA(STD_STA), .STD_SMP(STD_SMP), .STD_RST(STD_RST), .STD_REC(STD_REC),
    .STD_DLOW(STD_DLOW), .STD_DSMP(STD_DSMP),
    .HS_BIT(HS_BIT), .HS_ONE(HS_ONE), .HS_ZERO(HS_ZERO), .HS_STP(HS_STP),
    .HS_STA(HS_STA), .HS_SMP(HS_SMP), .HS_RST(HS_RST), .HS_REC(HS_REC),
    .HS_DLOW(HS_DLOW), .HS_DSMP(HS_DSMP)
  ) u_tsel (
    .hs (speed_hi),
    .ts (ts_w)
  );

  swb_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_data    (cmd_data),
    .cmd_ack_bit (cmd_ack_bit),
    .ts_in       (ts_w),
    .frame_end   (frame_end_w),
    .smp_bit     (smp_bit_w),
    .load        (load_w),
    .frm         (frm_w),
    .busy        (busy),
    .done        (done),
    .rx_data     (rx_data),
    .rx_nack     (rx_nack),
    .present     (present)
  );

  swb_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_w),
    .frm        (frm_w),
    .line_in    (line_in),
    .pull_low   (pull_low),
    .frame_end  (frame_end_w),
    .sample_stb (sample_stb_w),
    .smp_bit    (smp_bit_w),
    .active     (frame_act_w)
  );

endmodule

// File: rtl/swb_host_chk.sv
module swb_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       pull_low,
  input logic       frame_end,
  input logic       sample_stb,
  input logic       frame_active
);

  logic op_ok;
  assign op_ok = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && op_ok) |=> busy);

  p_bad_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && !op_ok) |=> !busy);

  p_no_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (frame_active || done));

  p_busy_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> frame_active);

  p_sample_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (frame_active && busy));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !frame_end) |=> busy);

  p_release_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pull_low);

endmodule

bind swb_host swb_host_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .busy         (busy),
  .done         (done),
  .pull_low     (pull_low),
  .frame_end    (frame_end_w),
  .sample_stb   (sample_stb_w),
  .frame_active (frame_act_w)
);

// File: tb/swb_host_tb.sv
module swb_host_tb_top;

  localparam int CLK_P = 10;
  // standard set
  localparam int SB = 24, S1 = 3, S0 = 12, SSTP = 17, SSTA = 21, SSMP = 8;
  localparam int SRST = 120, SREC = 10, SDL = 2, SDS = 6;
  // high-speed set
  localparam int HB = 12, H1 = 2, H0 = 7, HSTP = 9, HSTA = 10, HSMP = 4;
  localparam int HRST = 48, HREC = 6, HDL = 1, HDS = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       cmd_ack_bit = 1'b0;
  logic       speed_hi = 1'b0;
  logic       slave_low = 1'b0;
  logic       line_in;
  logic       pull_low, busy, done, rx_nack, present;
  logic [7:0] rx_data;

  assign line_in = !(pull_low || slave_low);

  swb_host dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_ack_bit(cmd_ack_bit), .speed_hi(speed_hi),
    .line_in(line_in), .pull_low(pull_low), .busy(busy), .done(done),
    .rx_data(rx_data), .rx_nack(rx_nack), .present(present)
  );

  always #(CLK_P/2) clk = ~clk;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit    q_pull[$];
  bit    q_slv[$];
  string q_tag[$];
  logic [7:0] e_rx = 8'd0;
  logic       e_nack = 1'b0;
  logic       e_pres = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic int pick(bit hs, int s, int h);
    return hs ? h : s;
  endfunction

  task automatic add_frame(int len, int low, int slo, string t);
    for (int j = 0; j < len; j++) begin
      q_pull.push_back(j < low);
      q_slv.push_back(j < slo);
      q_tag.push_back(t);
    end
  endtask

  // op: 1 reset, 2 start, 3 stop, 4 write, 5 read
  task automatic run(int op, logic [7:0] data, bit ackb, bit hs, logic [7:0] sbyte,
                     bit sack, bit sdev, bit disturb);
    int bl, l1, l0, smp;
    int n;
    bl  = pick(hs, SB, HB);
    l1  = pick(hs, S1, H1);
    l0  = pick(hs, S0, H0);
    smp = pick(hs, SSMP, HSMP);
    case (op)
      1: begin
        add_frame(pick(hs, SRST, HRST), pick(hs, SRST, HRST), 0, "R7");
        add_frame(pick(hs, SREC, HREC), 0, 0, "R7");
        add_frame(bl, pick(hs, SDL, HDL), sdev ? pick(hs, SDS, HDS) + 2 : 0, "R7");
        e_pres = sdev;
      end
      2: add_frame(bl, pick(hs, SSTA, HSTA), 0, "R6");
      3: add_frame(bl, pick(hs, SSTP, HSTP), 0, "R6");
      4: begin
        for (int b = 7; b >= 0; b--) add_frame(bl, data[b] ? l1 : l0, 0, "R4");
        add_frame(bl, l1, sack ? 0 : smp + 2, "R4");
        e_nack = sack;
      end
      default: begin
        for (int b = 7; b >= 0; b--) add_frame(bl, l1, sbyte[b] ? 0 : smp + 2, "R5");
        add_frame(bl, ackb ? l1 : l0, 0, "R5");
        e_rx = sbyte;
        e_nack = ackb;
      end
    endcase
    @(negedge clk);
    speed_hi = hs; cmd_op = 3'(op); cmd_data = data; cmd_ack_bit = ackb; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (q_pull.size() > 0) begin
      bit ep, es;
      string t;
      ep = q_pull.pop_front();
      es = q_slv.pop_front();
      t  = q_tag.pop_front();
      slave_low = es;
      chk(pull_low == ep && busy == 1'b1,
          {"R2 R3 R8 ", t, disturb ? " R10 R12" : ""}, "pull_low,busy",
          {pull_low, busy}, {ep, 1'b1});
      if (disturb && n == 3) begin cmd_valid = 1'b1; cmd_op = 3'd2; end
      if (disturb && n == 4) cmd_valid = 1'b0;
      if (disturb && n == 5) speed_hi = !hs;
      n++;
      @(negedge clk);
    end
    slave_low = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R9", "done,busy", {done, busy}, 2);
    chk(pull_low == 1'b0, "R11", "pull_low idle", pull_low, 0);
    chk(rx_data == e_rx, "R5 R9", "rx_data", rx_data, e_rx);
    chk(rx_nack == e_nack, "R4 R5 R9", "rx_nack", rx_nack, e_nack);
    chk(present == e_pres, "R7 R9", "present", present, e_pres);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done pulse width", done, 0);
    chk(busy == 1'b0 && pull_low == 1'b0, "R11", "idle after command", {busy, pull_low}, 0);
  endtask

  task automatic bad_op(logic [2:0] op);
    @(negedge clk);
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b0 && pull_low == 1'b0, "R2", "illegal op busy,pull", {busy, pull_low}, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R2", "illegal op done", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pull_low == 0 && busy == 0 && done == 0, "R1", "reset controls",
        {pull_low, busy, done}, 0);
    chk(rx_data == 0 && rx_nack == 0 && present == 0, "R1", "reset results",
        {rx_data, rx_nack, present}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    bad_op(3'd0);
    bad_op(3'd6);
    bad_op(3'd7);
    run(1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);  // R7 device found
    run(1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1);  // R7 none, R10 R12
    run(2, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);  // R6 start std
    run(4, 8'hA5, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);  // R4 ack
    run(4, 8'h3C, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);  // R4 nack
    run(5, 8'h00, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0, 1'b1);  // R5 std
    run(5, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);  // R5 hs nack
    run(5, 8'h00, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);  // R5 hs ack
    run(3, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);  // R6 stop std
    run(2, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);  // R6 start hs
    run(3, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);  // R6 stop hs
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule